// File: doc/BRIEF.md
# Circular Sector Buffer Manager

This block arbitrates a word-wide data buffer between a host transfer port and a local processor port. The host side moves data in bursts: the local processor loads a host pointer and a stop pointer, picks a direction and pulses a start strobe. While the burst runs, a data-request flag is raised. Every host strobe moves one word, or one byte in 8-bit mode. When the word at the stop pointer has been moved, the burst ends. A sticky completion flag then rises, and the block can optionally set a host busy flag, raise a host interrupt, or both.

The local processor reaches the buffer through a single access port that reads or writes the word at a local pointer. That pointer can step forward after each access. Both pointers are 16 bits wide and stay inside a circular window. A 3-bit select field sets the window from 512 words up to 32K words. The pointer bits above the window are kept, so the window sits at a fixed base. A disable input stops all buffer traffic. When both ports want the buffer in the same cycle, the host port wins.

Top module: `sbuf_mgr`

## Requirements
- R1: After reset, the host pointer and local pointer read 0000h and the stop pointer holds 00FFh, so a word burst started from reset moves exactly 256 words. `drq`, `xfer_done`, `host_busy`, `host_irq` and `lp_ack` are all low.
- R2: `win_sel` sets the window size W: 000 and 001 give 32K words, 010 gives 16K, 011 gives 8K, 100 gives 4K, 101 gives 2K, 110 gives 1K and 111 gives 512. Stepping a pointer whose low log2(W) bits are all ones clears those bits and leaves the higher bits unchanged. This holds for both the host pointer and the local pointer.
- R3: A `go` pulse starts a burst and `drq` reads 1 from the next cycle. With `dir`=0 each host strobe returns the buffer word at the host pointer on `hs_rdata` one cycle later. With `dir`=1 each host strobe writes `hs_wdata` at the host pointer.
- R4: The strobe that finishes the word at the host pointer equal to the stop pointer ends the burst. From the next cycle `drq` is 0, `xfer_done` is 1 and the host pointer has stepped once more. Later host strobes move nothing until the next `go`.
- R5: At completion, `host_busy` is set if `busy_on_done` is 1 and `host_irq` is set if `irq_on_done` is 1. Both stay set until the next `go` clears them.
- R6: A one-cycle `lp_req` reads (`lp_we`=0) or writes (`lp_we`=1) the word at the local pointer. `lp_ack`, and `lp_rdata` for a read, appear one cycle later. The local pointer steps after each access only when `auto_inc` is 1.
- R7: With `hs_byte`=1, a host word takes two strobes: the low byte first, then the high byte. Bytes travel on bit positions 7:0 and `hs_rdata[15:8]` reads 0. The host pointer steps only after the second strobe.
- R8: While `buf_disable` is 1, host and local requests are dropped. Both pointers hold, the buffer is not written and `lp_ack` stays 0.
- R9: When a host strobe and a local request fall in the same cycle, the host access is served first. The local access is served in the next free cycle, so `lp_ack` rises one cycle later than usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_sel | input | 3 | Circular window size select |
| auto_inc | input | 1 | Local pointer steps after each local access |
| buf_disable | input | 1 | Blocks all buffer accesses |
| busy_on_done | input | 1 | Set host busy flag at completion |
| irq_on_done | input | 1 | Raise host interrupt at completion |
| hs_byte | input | 1 | 8-bit host transfer mode |
| hptr_ld | input | 1 | Load host pointer from `ld_val` |
| stop_ld | input | 1 | Load stop pointer from `ld_val` |
| dptr_ld | input | 1 | Load local pointer from `ld_val` |
| ld_val | input | 16 | Pointer load value |
| go | input | 1 | Start a host burst |
| dir | input | 1 | Burst direction: 0 buffer to host, 1 host to buffer |
| hs_req | input | 1 | Host data strobe |
| hs_wdata | input | 16 | Host write data |
| hs_rdata | output | 16 | Host read data |
| lp_req | input | 1 | Local access request |
| lp_we | input | 1 | Local access is a write |
| lp_wdata | input | 16 | Local write data |
| lp_ack | output | 1 | Local access served |
| lp_rdata | output | 16 | Local read data |
| drq | output | 1 | Data request, burst in progress |
| xfer_done | output | 1 | Burst completed (sticky) |
| host_busy | output | 1 | Busy flag set at completion |
| host_irq | output | 1 | Interrupt set at completion |
| hptr | output | 16 | Host pointer |
| dptr | output | 16 | Local pointer |

## Verification
The whole 512-word buffer is filled through the local port with an arithmetic word pattern. It is then read back by a 256-word host burst from reset state, which separates a wrong default stop value from a wrong data path or a wrong end condition. An 8-bit write burst crosses the top of the window and is then read back in byte mode and through the local port, which shows whether bytes are swapped or the pointer wraps the wrong way. All eight window codes are swept with both pointers placed on the last word of their window. Directed collision, disable and post-completion strobes show whether the arbitration and the blocking act on the ports.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    localparam int BYTE_W = 8;
    localparam int DATA_W = 2 * BYTE_W;
    localparam int PTR_W  = 16;
    localparam int SEL_W  = 3;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_RUN  = 2'd1,
        XF_DONE = 2'd2
    } xfer_state_e;

    // pending local access held while the host owns the buffer
    typedef struct packed {
        logic              we;
        logic [DATA_W-1:0] data;
    } lp_cmd_t;

    // log2 of the circular window size in words
    function automatic logic [4:0] win_log2(input logic [SEL_W-1:0] sel);
        if (sel[2:1] == 2'b00) return 5'd15;
        return 5'd16 - {2'b00, sel};
    endfunction

endpackage

// File: rtl/sbuf_ptr.sv
module sbuf_ptr
    import sbuf_pkg::*;
#(
    parameter logic [PTR_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic             step,
    input  logic [PTR_W-1:0] ld_val,
    input  logic [PTR_W-1:0] mask,
    output logic [PTR_W-1:0] ptr
);

    logic [PTR_W-1:0] nxt;

    // step inside the window, keep the base bits above it
    always_comb nxt = (ptr & ~mask) | ((ptr + 1'b1) & mask);

    always_ff @(posedge clk) begin
        if (rst)       ptr <= RST_VAL;
        else if (ld)   ptr <= ld_val;
        else if (step) ptr <= nxt;
    end

endmodule

// File: rtl/sbuf_ram.sv
module sbuf_ram #(
    parameter int AW = 9,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/sbuf_xfer_ctl.sv
module sbuf_xfer_ctl
    import sbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic dir,
    input  logic byte_mode,
    input  logic hs_req,
    input  logic buf_disable,
    input  logic at_stop,
    input  logic busy_on_done,
    input  logic irq_on_done,
    output logic host_go,
    output logic word_fin,
    output logic phase,
    output logic dir_q,
    output logic drq,
    output logic done,
    output logic busy,
    output logic irq
);

    xfer_state_e st;

    assign drq      = (st == XF_RUN);
    assign done     = (st == XF_DONE);
    assign host_go  = hs_req & drq & ~buf_disable;
    assign word_fin = host_go & (~byte_mode | phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= XF_IDLE;
            phase <= 1'b0;
            dir_q <= 1'b0;
            busy  <= 1'b0;
            irq   <= 1'b0;
        end else if (go) begin
            st    <= XF_RUN;
            dir_q <= dir;
            phase <= 1'b0;
            busy  <= 1'b0;
            irq   <= 1'b0;
        end else if (word_fin) begin
            phase <= 1'b0;
            if (at_stop) begin
                st   <= XF_DONE;
                busy <= busy_on_done;
                irq  <= irq_on_done;
            end
        end else if (host_go) begin
            phase <= 1'b1;
        end
    end

endmodule

// File: rtl/sbuf_mgr.sv
module sbuf_mgr
    import sbuf_pkg::*;
#(
    parameter int MEM_AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  win_sel,
    input  logic              auto_inc,
    input  logic              buf_disable,
    input  logic              busy_on_done,
    input  logic              irq_on_done,
    input  logic              hs_byte,
    input  logic              hptr_ld,
    input  logic              stop_ld,
    input  logic              dptr_ld,
    input  logic [PTR_W-1:0]  ld_val,
    input  logic              go,
    input  logic              dir,
    input  logic              hs_req,
    input  logic [DATA_W-1:0] hs_wdata,
    output logic [DATA_W-1:0] hs_rdata,
    input  logic              lp_req,
    input  logic              lp_we,
    input  logic [DATA_W-1:0] lp_wdata,
    output logic              lp_ack,
    output logic [DATA_W-1:0] lp_rdata,
    output logic              drq,
    output logic              xfer_done,
    output logic              host_busy,
    output logic              host_irq,
    output logic [PTR_W-1:0]  hptr,
    output logic [PTR_W-1:0]  dptr
);

    logic [PTR_W-1:0]  win_mask;
    logic [PTR_W-1:0]  stop_q;
    logic              host_go, word_fin, phase, dir_q;
    logic              loc_go, pend_v;
    lp_cmd_t           pend_q, cur_cmd;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [BYTE_W-1:0] lo_hold;

    assign win_mask = ~({PTR_W{1'b1}} << win_log2(win_sel));

    sbuf_ptr #(.RST_VAL('0)) u_hptr (
        .clk(clk), .rst(rst), .ld(hptr_ld), .step(word_fin),
        .ld_val(ld_val), .mask(win_mask), .ptr(hptr)
    );

    sbuf_ptr #(.RST_VAL(16'h00FF)) u_stop (
        .clk(clk), .rst(rst), .ld(stop_ld), .step(1'b0),
        .ld_val(ld_val), .mask(win_mask), .ptr(stop_q)
    );

    sbuf_ptr #(.RST_VAL('0)) u_dptr (
        .clk(clk), .rst(rst), .ld(dptr_ld), .step(loc_go & auto_inc),
        .ld_val(ld_val), .mask(win_mask), .ptr(dptr)
    );

    sbuf_xfer_ctl u_ctl (
        .clk(clk), .rst(rst), .go(go), .dir(dir), .byte_mode(hs_byte),
        .hs_req(hs_req), .buf_disable(buf_disable), .at_stop(hptr == stop_q),
        .busy_on_done(busy_on_done), .irq_on_done(irq_on_done),
        .host_go(host_go), .word_fin(word_fin), .phase(phase), .dir_q(dir_q),
        .drq(drq), .done(xfer_done), .busy(host_busy), .irq(host_irq)
    );

    // local request: a fresh strobe or one parked behind the host
    always_comb begin
        if (lp_req) cur_cmd = '{we: lp_we, data: lp_wdata};
        else        cur_cmd = pend_q;
    end

    assign loc_go = (lp_req | pend_v) & ~host_go & ~buf_disable;

    // single buffer port, host first
    always_comb begin
        if (host_go) begin
            mem_addr  = hptr[MEM_AW-1:0];
            mem_we    = word_fin & dir_q;
            mem_wdata = hs_byte ? {hs_wdata[BYTE_W-1:0], lo_hold} : hs_wdata;
        end else begin
            mem_addr  = dptr[MEM_AW-1:0];
            mem_we    = loc_go & cur_cmd.we;
            mem_wdata = cur_cmd.data;
        end
    end

    sbuf_ram #(.AW(MEM_AW), .DW(DATA_W)) u_ram (
        .clk(clk), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_rdata <= '0;
            lo_hold  <= '0;
            lp_ack   <= 1'b0;
            lp_rdata <= '0;
            pend_v   <= 1'b0;
            pend_q   <= '0;
        end else begin
            lp_ack <= loc_go;
            if (host_go && !dir_q) begin
                if (!hs_byte)   hs_rdata <= mem_rdata;
                else if (phase) hs_rdata <= {{BYTE_W{1'b0}}, mem_rdata[DATA_W-1:BYTE_W]};
                else            hs_rdata <= {{BYTE_W{1'b0}}, mem_rdata[BYTE_W-1:0]};
            end
            if (host_go && dir_q && hs_byte && !phase)
                lo_hold <= hs_wdata[BYTE_W-1:0];
            if (loc_go && !cur_cmd.we)
                lp_rdata <= mem_rdata;
            if (buf_disable) begin
                pend_v <= 1'b0;
            end else if (lp_req && host_go) begin
                pend_v <= 1'b1;
                pend_q <= cur_cmd;
            end else if (loc_go) begin
                pend_v <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sbuf_mgr_chk.sv
module sbuf_mgr_chk
    import sbuf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             buf_disable,
    input logic             busy_on_done,
    input logic             irq_on_done,
    input logic             hptr_ld,
    input logic             dptr_ld,
    input logic             go,
    input logic             hs_req,
    input logic             lp_req,
    input logic             lp_ack,
    input logic             drq,
    input logic             xfer_done,
    input logic             host_busy,
    input logic             host_irq,
    input logic [PTR_W-1:0] hptr,
    input logic [PTR_W-1:0] dptr,
    input logic [PTR_W-1:0] stop_q
);

    AST_GO_RAISES_DRQ: assert property (@(posedge clk) disable iff (rst)
        go |=> drq); // R3

    AST_DONE_EXCLUDES_DRQ: assert property (@(posedge clk) disable iff (rst)
        !(xfer_done && drq)); // R4

    AST_DONE_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_done) |-> $past(hptr) == $past(stop_q)); // R4

    AST_BUSY_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(host_busy) |-> ($past(busy_on_done) && xfer_done)); // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(host_irq) |-> ($past(irq_on_done) && xfer_done)); // R5

    AST_DISABLE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        buf_disable |=> !lp_ack); // R8

    AST_DISABLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (buf_disable && !hptr_ld && !dptr_ld) |=> ($stable(hptr) && $stable(dptr))); // R8

    AST_HOST_FIRST: assert property (@(posedge clk) disable iff (rst)
        (hs_req && drq && !buf_disable && lp_req) |=> !lp_ack); // R9

endmodule

bind sbuf_mgr sbuf_mgr_chk u_chk (
    .clk(clk), .rst(rst), .buf_disable(buf_disable),
    .busy_on_done(busy_on_done), .irq_on_done(irq_on_done),
    .hptr_ld(hptr_ld), .dptr_ld(dptr_ld), .go(go), .hs_req(hs_req),
    .lp_req(lp_req), .lp_ack(lp_ack), .drq(drq), .xfer_done(xfer_done),
    .host_busy(host_busy), .host_irq(host_irq), .hptr(hptr), .dptr(dptr),
    .stop_q(stop_q)
);

// File: tb/sbuf_mgr_bench.sv
module sbuf_mgr_bench;

    localparam int CLK_P = 10;
    localparam int WORDS = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  win_sel = 3'd7;
    logic        auto_inc = 1'b1, buf_disable = 1'b0;
    logic        busy_on_done = 1'b0, irq_on_done = 1'b0, hs_byte = 1'b0;
    logic        hptr_ld = 1'b0, stop_ld = 1'b0, dptr_ld = 1'b0;
    logic [15:0] ld_val = '0;
    logic        go = 1'b0, dir = 1'b0, hs_req = 1'b0;
    logic [15:0] hs_wdata = '0, hs_rdata;
    logic        lp_req = 1'b0, lp_we = 1'b0, lp_ack;
    logic [15:0] lp_wdata = '0, lp_rdata;
    logic        drq, xfer_done, host_busy, host_irq;
    logic [15:0] hptr, dptr;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] model [0:WORDS-1];

    always #(CLK_P/2) clk = ~clk;

    sbuf_mgr u_sbuf_mgr (
        .clk(clk), .rst(rst), .win_sel(win_sel), .auto_inc(auto_inc),
        .buf_disable(buf_disable), .busy_on_done(busy_on_done),
        .irq_on_done(irq_on_done), .hs_byte(hs_byte), .hptr_ld(hptr_ld),
        .stop_ld(stop_ld), .dptr_ld(dptr_ld), .ld_val(ld_val), .go(go),
        .dir(dir), .hs_req(hs_req), .hs_wdata(hs_wdata), .hs_rdata(hs_rdata),
        .lp_req(lp_req), .lp_we(lp_we), .lp_wdata(lp_wdata), .lp_ack(lp_ack),
        .lp_rdata(lp_rdata), .drq(drq), .xfer_done(xfer_done),
        .host_busy(host_busy), .host_irq(host_irq), .hptr(hptr), .dptr(dptr)
    );

    function automatic logic [15:0] pat(input int i);
        logic [31:0] p;
        p = i * 32'h9E37;
        return p[15:0] ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] mask_of(input int s);
        int b;
        b = (s < 2) ? 15 : 16 - s;
        return 16'((32'd1 << b) - 1);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic ld_h(input logic [15:0] v);
        hptr_ld = 1'b1; ld_val = v; tick(); hptr_ld = 1'b0;
    endtask

    task automatic ld_s(input logic [15:0] v);
        stop_ld = 1'b1; ld_val = v; tick(); stop_ld = 1'b0;
    endtask

    task automatic ld_d(input logic [15:0] v);
        dptr_ld = 1'b1; ld_val = v; tick(); dptr_ld = 1'b0;
    endtask

    task automatic start(input logic d);
        go = 1'b1; dir = d; tick(); go = 1'b0;
    endtask

    task automatic lwr(input logic [15:0] v);
        lp_req = 1'b1; lp_we = 1'b1; lp_wdata = v; tick();
        lp_req = 1'b0; lp_we = 1'b0;
        chk("R6 write ack", lp_ack, 1);
    endtask

    task automatic lrd(output logic [15:0] v);
        lp_req = 1'b1; lp_we = 1'b0; tick();
        lp_req = 1'b0;
        chk("R6 read ack", lp_ack, 1);
        v = lp_rdata;
    endtask

    task automatic hstb(input logic [15:0] v);
        hs_req = 1'b1; hs_wdata = v; tick(); hs_req = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic [15:0] m, base;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 hptr", hptr, 16'h0000);
        chk("R1 dptr", dptr, 16'h0000);
        chk("R1 drq", drq, 0);
        chk("R1 done", xfer_done, 0);
        chk("R1 busy", host_busy, 0);
        chk("R1 irq", host_irq, 0);
        chk("R1 ack", lp_ack, 0);

        // R6 fill with auto-increment, R2 wrap at 512
        for (int i = 0; i < WORDS; i++) begin
            model[i] = pat(i);
            lwr(pat(i));
        end
        chk("R2 dptr wrap after fill", dptr, 16'h0000);

        // R6 no auto-increment
        auto_inc = 1'b0;
        ld_d(16'h0005);
        lrd(rd); chk("R6 read no-inc", rd, model[5]);
        lrd(rd); chk("R6 reread no-inc", rd, model[5]);
        chk("R6 dptr held", dptr, 16'h0005);
        auto_inc = 1'b1;

        // R3/R1: word read burst with default stop
        busy_on_done = 1'b1; irq_on_done = 1'b0;
        start(1'b0);
        chk("R3 drq after go", drq, 1);
        for (int i = 0; i < 256; i++) begin
            hstb(16'h0000);
            chk("R3 host read data", hs_rdata, model[i]);
            if (i == 254) chk("R1 not done before stop", xfer_done, 0);
        end
        chk("R4 done", xfer_done, 1);
        chk("R4 drq low", drq, 0);
        chk("R1 stop default 256 words", hptr, 16'h0100);
        chk("R5 busy set", host_busy, 1);
        chk("R5 irq not set", host_irq, 0);
        hstb(16'h0000);
        chk("R4 strobe after done ignored", hptr, 16'h0100);
        chk("R4 still done", xfer_done, 1);

        // R7 byte write burst crossing the window top
        hs_byte = 1'b1;
        ld_h(16'h01FE); ld_s(16'h0001);
        busy_on_done = 1'b0; irq_on_done = 1'b1;
        start(1'b1);
        chk("R5 busy cleared by go", host_busy, 0);
        chk("R5 done cleared by go", xfer_done, 0);
        for (int k = 0; k < 8; k++) begin
            hstb(16'hEE30 + 16'(k));
            if (k == 0) chk("R7 hptr holds after low byte", hptr, 16'h01FE);
            if (k == 1) chk("R7 hptr steps after high byte", hptr, 16'h01FF);
        end
        for (int j = 0; j < 4; j++)
            model[(16'h01FE + j) % WORDS] = {8'h31 + 8'(2*j), 8'h30 + 8'(2*j)};
        chk("R2 hptr wrapped", hptr, 16'h0002);
        chk("R4 byte burst done", xfer_done, 1);
        chk("R5 irq set", host_irq, 1);
        chk("R5 busy not set", host_busy, 0);

        // R7 byte read burst
        ld_h(16'h01FF); ld_s(16'h0000);
        start(1'b0);
        hstb(16'h0000); chk("R7 low byte first", hs_rdata, {8'h00, model[511][7:0]});
        hstb(16'h0000); chk("R7 high byte second", hs_rdata, {8'h00, model[511][15:8]});
        hstb(16'h0000); chk("R7 next low byte", hs_rdata, {8'h00, model[0][7:0]});
        hstb(16'h0000); chk("R7 next high byte", hs_rdata, {8'h00, model[0][15:8]});
        chk("R4 byte read done", xfer_done, 1);
        hs_byte = 1'b0;

        // R7 byte-written words seen through the local port
        ld_d(16'h01FE);
        for (int j = 0; j < 4; j++) begin
            lrd(rd);
            chk("R7 local view of byte writes", rd, model[(16'h01FE + j) % WORDS]);
        end

        // R9 collision
        ld_h(16'h0010); ld_s(16'h0020);
        start(1'b0);
        ld_d(16'h0040);
        hs_req = 1'b1; lp_req = 1'b1; lp_we = 1'b0;
        tick();
        hs_req = 1'b0; lp_req = 1'b0;
        chk("R9 local waits", lp_ack, 0);
        chk("R9 host served", hs_rdata, model[16'h10]);
        tick();
        chk("R9 local served next", lp_ack, 1);
        chk("R9 local data", lp_rdata, model[16'h40]);
        chk("R9 dptr stepped", dptr, 16'h0041);

        // R8 disable
        buf_disable = 1'b1;
        lp_req = 1'b1; lp_we = 1'b1; lp_wdata = 16'hDEAD; hs_req = 1'b1;
        tick();
        lp_req = 1'b0; lp_we = 1'b0; hs_req = 1'b0;
        chk("R8 no ack", lp_ack, 0);
        tick();
        chk("R8 still no ack", lp_ack, 0);
        chk("R8 hptr frozen", hptr, 16'h0011);
        chk("R8 dptr frozen", dptr, 16'h0041);
        chk("R8 burst still open", drq, 1);
        buf_disable = 1'b0;
        tick();
        lrd(rd);
        chk("R8 buffer not written", rd, model[16'h41]);

        // R2 window sweep, both pointers on the last word of the window
        for (int s = 0; s < 8; s++) begin
            win_sel = 3'(s);
            m = mask_of(s);
            base = 16'hA000 & ~m;
            ld_d(16'hA000 | m);
            lrd(rd);
            chk("R2 dptr window wrap", dptr, base);
            ld_h(16'hA000 | m); ld_s(16'hA000 | m);
            start(1'b0);
            hstb(16'h0000);
            chk("R4 single word burst done", xfer_done, 1);
            chk("R2 hptr window wrap", hptr, base);
        end
        win_sel = 3'd7;

        summary();
        $finish;
    end

endmodule